// File: doc/BRIEF.md
# UART Interrupt Source and Mask Unit

This block gathers the interrupt causes of one serial channel into a single level-sensitive request line. It has three small registers: a sticky source register that records which events have occurred, a mask register, and a pending view derived from the two. Four event inputs set the source bits. A fifth cause comes from transmit FIFO occupancy. When FIFO mode is on and the transmit FIFO holds no more entries than a programmable threshold, the transmit source bit is raised on every cycle.

The threshold is a 3-bit selector multiplied by a factor that is fixed by the `CHANNEL` parameter. Software reads the three registers through a simple word-addressed port. Software acknowledges interrupts by writing ones to the pending or source register, and it gates causes by rewriting the mask. The events themselves are produced elsewhere.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source, mask and pending registers all read zero and `irq` is low.
- R2: A one-cycle pulse on `ev_rx`, `ev_err`, `ev_tx` or `ev_modem` sets source bit 0, 1, 2 or 3 respectively. The bit is visible from the next clock edge and stays set until it is cleared.
- R3: Pending equals source AND NOT mask, bit by bit. `irq` is high exactly when any pending bit is set.
- R4: A write to offset 0x30 (pending) clears, in source and therefore in pending, every bit whose data bit [3:0] is 1. The other bits are unchanged.
- R5: A write to offset 0x34 (source) clears every source bit written as 1. The other bits are unchanged.
- R6: A write to offset 0x38 replaces the mask with data bits [3:0]. Pending and `irq` follow the new mask from the next edge, and the source is untouched.
- R7: The transmit threshold is `tx_trig_sel` times a scale: 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel. When `fifo_en` is 1 and `tx_count` is at most the threshold, source bit 2 is set.
- R8: When `fifo_en` is 0, the FIFO count and the threshold have no effect on the source.
- R9: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: Reads of the three registers return zero in bits [31:4]. Other offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset for the read and the write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `reg_addr`, combinational |
| ev_rx | input | 1 | Receive event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_tx | input | 1 | Transmit event pulse |
| ev_modem | input | 1 | Modem event pulse |
| fifo_en | input | 1 | FIFO mode enable |
| tx_trig_sel | input | 3 | Transmit threshold selector |
| tx_count | input | CNT_W | Current transmit FIFO occupancy |
| irq | output | 1 | Level interrupt request |

## Verification
The only state is the source and mask bits. A wrong value in either one shows up on the very next read of offset 0x34 or 0x38. It also shows up as a wrong `irq` level in the same cycle, because pending is derived combinationally. A lost event, or a clear that wins over a set, leaves a bit low that software would never see. For that reason the bench checks the register contents right after each edge that could change them. This includes the edge where a clear and a set collide, and the threshold boundary at `count == level` compared with `level + 1`.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int CHANNEL = 0,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_rx,
  input  logic              ev_err,
  input  logic              ev_tx,
  input  logic              ev_modem,
  input  logic              fifo_en,
  input  logic [2:0]        tx_trig_sel,
  input  logic [CNT_W-1:0]  tx_count,
  output logic              irq
);
  localparam int NSRC  = 4;
  localparam int LVL_W = CNT_W + 8;
  localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] OFF_SRC  = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'('h38);

  function automatic int trig_scale(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

  localparam int SCALE = trig_scale(CHANNEL);

  logic [NSRC-1:0]  src_q, mask_q, pend, set_vec, clr_vec;
  logic [LVL_W-1:0] tx_level;
  logic             tx_low, unused_hi;

  assign tx_level = LVL_W'(tx_trig_sel) * LVL_W'(SCALE);
  assign tx_low   = fifo_en && (LVL_W'(tx_count) <= tx_level);
  assign set_vec  = {ev_modem, ev_tx | tx_low, ev_err, ev_rx};
  assign clr_vec  = (wr_en && (reg_addr == OFF_PEND || reg_addr == OFF_SRC))
                    ? wr_data[NSRC-1:0] : '0;
  assign pend     = src_q & ~mask_q;
  assign irq      = |pend;
  assign unused_hi = ^wr_data[DATA_W-1:NSRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q <= (src_q & ~clr_vec) | set_vec;
      if (wr_en && reg_addr == OFF_MASK) mask_q <= wr_data[NSRC-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr)
      OFF_PEND: rd_data[NSRC-1:0] = pend;
      OFF_SRC:  rd_data[NSRC-1:0] = src_q;
      OFF_MASK: rd_data[NSRC-1:0] = mask_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wr_en,
  input logic [3:0]        wr_lo,
  input logic [3:0]        src_q,
  input logic [3:0]        mask_q,
  input logic [3:0]        set_vec,
  input logic              irq
);
  logic wr_pend, wr_src, wr_mask;
  assign wr_pend = wr_en && reg_addr == ADDR_W'('h30);
  assign wr_src  = wr_en && reg_addr == ADDR_W'('h34);
  assign wr_mask = wr_en && reg_addr == ADDR_W'('h38);

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((src_q & $past(set_vec)) == $past(set_vec)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == 4'b0 && !wr_pend && !wr_src) |=> $stable(src_q));

  assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((src_q & $past(wr_lo) & ~$past(set_vec)) == 4'b0));

  assert_src_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_src |=> ((src_q & $past(wr_lo) & ~$past(set_vec)) == 4'b0));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wr_lo)));

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'hF || src_q == 4'h0) |-> !irq);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
  .wr_lo(wr_data[3:0]), .src_q(src_q), .mask_q(mask_q),
  .set_vec(set_vec), .irq(irq)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ev_rx = 0, ev_err = 0, ev_tx = 0, ev_modem = 0;
  logic        fifo_en = 0;
  logic [2:0]  tx_trig_sel = '0;
  logic [7:0]  tx_count = 8'd100;
  logic        irq;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ev_rx(ev_rx), .ev_err(ev_err),
    .ev_tx(ev_tx), .ev_modem(ev_modem), .fifo_en(fifo_en),
    .tx_trig_sel(tx_trig_sel), .tx_count(tx_count), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk); {ev_modem, ev_tx, ev_err, ev_rx} = ev;
    @(negedge clk); {ev_modem, ev_tx, ev_err, ev_rx} = 4'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h30, d); check("R1 pend", d, 0);
    rd(8'h34, d); check("R1 src", d, 0);
    rd(8'h38, d); check("R1 mask", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      pulse(4'(1 << i));
      rd(8'h34, d); check("R2 src bit", d, 32'(1 << i));
      rd(8'h30, d); check("R3 pend unmasked", d, 32'(1 << i));
      check("R3 irq", {31'b0, irq}, 1);
      wr(8'h34, 32'hF);
    end
    rd(8'h34, d); check("R5 all cleared", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    pulse(4'b0101);
    wr(8'h38, 32'h1);
    rd(8'h30, d); check("R6 pend after mask", d, 32'h4);
    check("R3 irq partly masked", {31'b0, irq}, 1);
    wr(8'h38, 32'hFFFF_FFF5);
    rd(8'h38, d); check("R10 mask upper zero", d, 32'h5);
    rd(8'h30, d); check("R6 pend fully masked", d, 0);
    check("R3 irq masked", {31'b0, irq}, 0);
    rd(8'h34, d); check("R6 src untouched", d, 32'h5);
    wr(8'h38, 32'h0);
    wr(8'h34, 32'hF);
  endtask

  task automatic t_clears;
    logic [31:0] d;
    pulse(4'hF);
    wr(8'h30, 32'h3);
    rd(8'h34, d); check("R4 pend write clears src", d, 32'hC);
    rd(8'h30, d); check("R4 pend view", d, 32'hC);
    wr(8'h34, 32'h4);
    rd(8'h34, d); check("R5 src write", d, 32'h8);
    wr(8'h34, 32'hF);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk); reg_addr = 8'h34; wr_data = 32'h1; wr_en = 1; ev_rx = 1;
    @(negedge clk); wr_en = 0; ev_rx = 0;
    rd(8'h34, d); check("R9 set wins", d, 32'h1);
    wr(8'h34, 32'hF);
  endtask

  task automatic t_thresh;
    logic [31:0] d;
    @(negedge clk); tx_trig_sel = 3'd1; tx_count = 8'd33; fifo_en = 1;
    @(negedge clk);
    rd(8'h34, d); check("R7 count above level", d, 0);
    tx_count = 8'd32;
    @(negedge clk);
    rd(8'h34, d); check("R7 count at level", d, 32'h4);
    fifo_en = 0; wr(8'h34, 32'hF);
    rd(8'h34, d); check("R7 cleared after disable", d, 0);
    @(negedge clk); tx_trig_sel = 3'd0; tx_count = 8'd0; fifo_en = 1;
    @(negedge clk);
    rd(8'h34, d); check("R7 level zero count zero", d, 32'h4);
    fifo_en = 0; wr(8'h34, 32'hF);
    @(negedge clk); @(negedge clk);
    rd(8'h34, d); check("R8 disabled no effect", d, 0);
    check("R8 irq", {31'b0, irq}, 0);
    tx_count = 8'd100;
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    pulse(4'b0010);
    wr(8'h3C, 32'hF);
    wr(8'h00, 32'hF);
    rd(8'h3C, d); check("R10 unmapped read", d, 0);
    rd(8'h34, d); check("R10 src unchanged", d, 32'h2);
    rd(8'h38, d); check("R10 mask unchanged", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_events();
    t_mask();
    t_clears();
    t_collide();
    t_thresh();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule